// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host-side master for a 14-bit serial sampling converter. It divides the system clock into a serial clock, lowers chip select to start each conversion, and reads back the bit stream the converter shifts out. It removes the framing zeros and presents the result as a straight-binary word with a one-cycle valid strobe. While chip select is high, the acquisition phase runs for a number of serial-clock periods set by the host. The conversion phase then runs for a set number of periods with chip select low.

The word read in a frame comes from the conversion that the previous frame started. The first frame after reset therefore carries no real data, and it is flagged as stale. The serial clock can be held low, held high, or kept running during acquisition. The number of leading zeros depends on that choice, so the sampling positions change with it. Every zero the reader expects is checked, and a frame-error flag is raised if any of them reads as one.

Top module: `adc_frame_reader`

## Requirements
- R1: One serial-clock period is 2*HALF system cycles. Chip select stays low for exactly `conv_periods` periods. When frames run back to back, chip select stays high for exactly `acq_periods` periods between them.
- R2: Chip select rises only after at least 16 serial-clock falling edges have occurred while it was low. This requires `conv_periods` of at least 17 in mode 0 and at least 16 in the other modes.
- R3: The acquisition clock pattern follows the mode code. Code 0 holds the clock low. Code 1 holds it high. Codes 2 and 3 run it continuously, each period high then low, so that its rising edge coincides with the fall of chip select.
- R4: Data is sampled on rising edges, counted from 1 after chip select falls. In mode 0, edge 1 carries a zero, edges 2 to 15 carry bits 13 down to 0, and edge 16 carries a trailing zero. In the other modes, a zero is also sampled just before the first falling edge, edge 1 carries a zero, and edges 2 to 15 carry the data.
- R5: `smp_data_o` holds the 14 bits assembled MSB first. `smp_valid_o` pulses for one cycle, in the same cycle that chip select rises.
- R6: `smp_stale_o` is 1 for the first frame after reset and 0 for every later frame.
- R7: `frame_err_o` is 1 for a frame in which any zero position named in R4 reads as one. Samples taken after the 16th falling edge are ignored.
- R8: If `run` is high when a frame ends, the next acquisition starts at once. Otherwise the block goes idle with chip select high and the clock at the level set by the mode: low for mode 0, high for the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Start frames and keep them running back to back |
| mode | input | 2 | Acquisition clock pattern, latched at frame start |
| acq_periods | input | PW | Acquisition length in serial-clock periods |
| conv_periods | input | PW | Conversion length in serial-clock periods |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| smp_data_o | output | DW | Sample from the previous conversion |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| smp_stale_o | output | 1 | Sample belongs to no real conversion |
| frame_err_o | output | 1 | A framing zero read as one |

## Verification
The assertions take for granted that `conv_periods` is long enough for the chosen mode, that `acq_periods` is at least 1, and that the converter changes its output only on falling clock edges. The stimulus picks conversion lengths of 17 or 19 in mode 0 and 16 or 18 in the other modes. It changes configuration only while the block is idle. The converter model in the bench changes its data only on falling edges and drives idle or released positions high, so any extra sample the reader took would show as an error.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DW   = 14,
  parameter int HALF = 2,
  parameter int PW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] acq_periods,
  input  logic [PW-1:0] conv_periods,
  input  logic          sdo_i,
  output logic          cs_n_o,
  output logic          sck_o,
  output logic [DW-1:0] smp_data_o,
  output logic          smp_valid_o,
  output logic          smp_stale_o,
  output logic          frame_err_o
);
  localparam int DCW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int FRAME = DW + 2;
  localparam logic [1:0] M_LOW = 2'd0, M_HIGH = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV} st_t;

  st_t           st, st_nx;
  logic [1:0]    md_q, md_nx;
  logic [PW-1:0] acq_q, acq_nx, conv_q, conv_nx, per, per_nx;
  logic          hf, hf_nx;
  logic [DCW-1:0] div, div_nx;
  logic [DW-1:0] shreg;
  logic          err, seen;

  function automatic logic sck_of(st_t s, logic [1:0] m, logic h);
    case (s)
      S_ACQ:   return (m == M_LOW) ? 1'b0 : (m == M_HIGH) ? 1'b1 : !h;
      S_CONV:  return (m == M_LOW) ? h : !h;
      default: return m != M_LOW;
    endcase
  endfunction

  wire           tick      = div == DCW'(HALF - 1);
  wire           low_md    = md_q == M_LOW;
  wire [PW-1:0]  k         = per + PW'(1);
  wire           in_conv   = st == S_CONV;
  wire           samp_rise = in_conv && tick && (low_md ? !hf : hf);
  wire           pre_samp  = in_conv && tick && !low_md && !hf && per == '0;
  wire           chk_zero  = pre_samp || (samp_rise && (k == PW'(1) || (low_md && k == PW'(FRAME))));
  wire           is_data   = samp_rise && k >= PW'(2) && k <= PW'(DW + 1);
  wire           frame_end = in_conv && tick && hf && per == conv_q - PW'(1);
  wire           sck_nx    = sck_of(st_nx, md_nx, hf_nx);

  always_comb begin
    st_nx = st; md_nx = md_q; acq_nx = acq_q; conv_nx = conv_q;
    per_nx = per; hf_nx = hf;
    div_nx = tick ? '0 : div + DCW'(1);
    case (st)
      S_IDLE: begin
        div_nx = '0;
        if (run) begin
          st_nx = S_ACQ; md_nx = mode; acq_nx = acq_periods; conv_nx = conv_periods;
          per_nx = '0; hf_nx = 1'b0;
        end
      end
      S_ACQ: if (tick) begin
        hf_nx = !hf;
        if (hf) begin
          per_nx = per + PW'(1);
          if (per == acq_q - PW'(1)) begin st_nx = S_CONV; per_nx = '0; end
        end
      end
      default: if (tick) begin
        hf_nx = !hf;
        if (hf) begin
          per_nx = per + PW'(1);
          if (frame_end) begin
            per_nx = '0;
            if (run) begin
              st_nx = S_ACQ; md_nx = mode; acq_nx = acq_periods; conv_nx = conv_periods;
            end else st_nx = S_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; md_q <= M_LOW; acq_q <= '0; conv_q <= '0;
      per <= '0; hf <= 1'b0; div <= '0;
      cs_n_o <= 1'b1; sck_o <= 1'b0;
      shreg <= '0; err <= 1'b0; seen <= 1'b0;
      smp_data_o <= '0; smp_valid_o <= 1'b0; smp_stale_o <= 1'b0; frame_err_o <= 1'b0;
    end else begin
      st <= st_nx; md_q <= md_nx; acq_q <= acq_nx; conv_q <= conv_nx;
      per <= per_nx; hf <= hf_nx; div <= div_nx;
      cs_n_o <= st_nx != S_CONV;
      sck_o  <= sck_nx;
      if (is_data) shreg <= {shreg[DW-2:0], sdo_i};
      if (st == S_ACQ && st_nx == S_CONV) err <= 1'b0;
      else if (chk_zero && sdo_i) err <= 1'b1;
      smp_valid_o <= frame_end;
      if (frame_end) begin
        smp_data_o  <= shreg;
        smp_stale_o <= !seen;
        frame_err_o <= err;
        seen        <= 1'b1;
      end
    end
  end

  logic [PW-1:0] nfall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nfall <= '0;
    else if (cs_n_o) nfall <= '0;
    else if (sck_o && !sck_nx && st_nx == S_CONV) nfall <= nfall + PW'(1);
  end

  a_r2_cs_after_falls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> nfall >= PW'(FRAME));
  a_r5_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> $rose(cs_n_o));
  a_r3_low_acq_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && md_q == M_LOW) |-> !sck_o);
  a_r3_high_acq_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && md_q == M_HIGH) |-> sck_o);
  a_r1_cs_stable_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && !(tick && hf)) |=> !cs_n_o);
endmodule

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;
  localparam int DW = 14, HALF = 2, PW = 6, PER = 2 * HALF;

  logic clk = 0, rst_n = 0, run = 0;
  logic [1:0] mode = 0;
  logic [PW-1:0] acq_periods = 1, conv_periods = 17;
  logic sdo;
  logic cs_n, sck, valid, stale, ferr;
  logic [DW-1:0] data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_frame_reader #(.DW(DW), .HALF(HALF), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
    .acq_periods(acq_periods), .conv_periods(conv_periods), .sdo_i(sdo),
    .cs_n_o(cs_n), .sck_o(sck), .smp_data_o(data), .smp_valid_o(valid),
    .smp_stale_o(stale), .frame_err_o(ferr));

  function automatic logic [DW-1:0] val(int n);
    if (n % 7 == 3) return '1;
    if (n % 7 == 5) return '0;
    return DW'((n * 4093 + 341) % 16384);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // converter model
  int nconv = 0, f = 0, bad_f = -1;
  logic [DW-1:0] word = 0;
  int cur_mode = 0, cur_acq = 1, cur_conv = 17;

  function automatic logic bitv(int pos);
    if (pos == 0) return 1'b0;
    if (cur_mode != 0) begin
      if (pos == 1) return 1'b0;
      if (pos <= 15) return word[15-pos];
      return 1'b1;
    end
    if (pos <= 14) return word[14-pos];
    if (pos == 15) return 1'b0;
    return 1'b1;
  endfunction

  always @(negedge cs_n) begin
    word = (nconv == 0) ? DW'('h2AAA) : val(nconv - 1);
    nconv++;
    f = 0;
  end
  always @(negedge sck) if (!cs_n) f = f + 1;
  assign sdo = cs_n ? 1'b1 : (f == bad_f) ? 1'b1 : bitv(f);

  // monitor
  int vidx = 0, lowcnt = 0, gapcnt = 0, rises = 0, falls = 0;
  bit exp_err = 0, gap_chk = 0, prev_cs = 1, prev_sck = 0;
  always @(negedge clk) if (rst_n && !done) begin
    if (valid) begin
      check(stale == (vidx == 0), "R6", "stale", stale, vidx == 0);
      if (vidx > 0) check(data == val(vidx - 1), "R5", "data", data, val(vidx - 1));
      check(ferr == exp_err, "R7", "frame_err", ferr, exp_err);
      vidx++;
    end
    if (cs_n && !prev_cs) begin
      check(lowcnt == cur_conv * PER, "R1", "cs low cycles", lowcnt, cur_conv * PER);
      check(falls >= 16, "R2", "falls before cs rise", falls, 16);
      check(valid, "R5", "valid at cs rise", valid, 1);
      gap_chk = run; gapcnt = 0; rises = 0;
    end
    if (!cs_n && prev_cs) begin
      if (gap_chk) begin
        check(gapcnt == cur_acq * PER, "R8", "back-to-back gap", gapcnt, cur_acq * PER);
        check(rises == ((cur_mode == 0) ? 0 : (cur_mode == 1) ? 1 : cur_acq),
              "R3", "acq clock rises", rises,
              (cur_mode == 0) ? 0 : (cur_mode == 1) ? 1 : cur_acq);
      end
      lowcnt = 0; falls = 0;
    end
    if (cs_n) begin gapcnt++; if (sck && !prev_sck) rises++; end
    else begin lowcnt++; if (!sck && prev_sck) falls++; end
    prev_cs = cs_n; prev_sck = sck;
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    nconv = 0; vidx = 0; prev_cs = 1; prev_sck = 0; gap_chk = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic do_frames(int m, int a, int c, int n);
    int start;
    cur_mode = m; cur_acq = a; cur_conv = c;
    mode = 2'(m); acq_periods = PW'(a); conv_periods = PW'(c);
    start = vidx;
    run = 1;
    if (n > 1) wait (vidx == start + n - 1);
    @(negedge clk);
    run = 0;
    wait (vidx == start + n);
    repeat (4) @(negedge clk);
    check(cs_n == 1'b1, "R8", "idle cs", cs_n, 1);
    check(sck == (m != 0), "R8", "idle sck level", sck, m != 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(cs_n == 1'b1 && sck == 1'b0 && valid == 1'b0, "R1", "reset state",
          {cs_n, sck, valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      do_reset();
      for (int ai = 0; ai < 3; ai++)
        for (int j = 0; j < 2; j++)
          do_frames(m, (ai == 2) ? 5 : ai + 1, ((m == 0) ? 17 : 16) + 2 * j, 3);
    end
    // R7 and R4: corrupt each checked zero position in turn
    do_reset();
    do_frames(0, 2, 17, 1);
    bad_f = 0;  exp_err = 1; do_frames(0, 2, 17, 1);
    bad_f = 15; exp_err = 1; do_frames(0, 2, 17, 1);
    bad_f = -1; exp_err = 0; do_frames(0, 2, 17, 1);
    bad_f = 0;  exp_err = 1; do_frames(1, 1, 16, 1);
    bad_f = 1;  exp_err = 1; do_frames(2, 3, 16, 1);
    bad_f = 1;  exp_err = 1; do_frames(1, 2, 18, 1);
    bad_f = 16; exp_err = 0; do_frames(1, 2, 18, 1);
    bad_f = -1; exp_err = 0; do_frames(3, 2, 16, 2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule